// File: doc/BRIEF.md
# Hardware Cursor Overlay

This stage sits in a display pipeline and paints a small cursor image over a stream of RGB pixels. Each incoming pixel carries its screen coordinates, a valid flag and a frame-start flag. The cursor image is stored inside the block at two bits per cell. A cell at row `r`, column `c` of the image covers screen pixel (`pos_x + c`, `pos_y + r`). The image is loaded through a one-cell-per-cycle write port. Every pixel leaves the block exactly two cycles after it enters, together with its valid and frame-start flags.

Each covered pixel's 2-bit code is read from the image and then decoded under one of two modes. In the tricolour mode the code selects one of three programmable colours, or it leaves the pixel alone. In the two-colour mode two codes select colours, one code leaves the pixel alone and one code complements the background. A painted colour is mixed with the background using a 4-bit alpha. The cursor position is copied into internal registers only when a valid frame-start pixel arrives. A position change in the middle of a frame therefore cannot split the cursor across two places.

A two-state machine controls when the cursor may appear. `ST_NO_FRAME` is entered at reset, and no pixel can be painted in it. The transition *first frame start* (a valid pixel with the frame-start flag set) moves it to `ST_IN_FRAME`. That state is held until the next reset. The transition also loads the position registers, and it does the same on every later frame start.

Top module: `hwc_overlay`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid`, `out_sof` and `out_rgb` are all zero.
- R2: `out_valid` and `out_sof` equal `in_valid` and `in_sof` from two cycles earlier, and `out_rgb` is the result for the pixel presented two cycles earlier.
- R3: A pixel passes through unchanged when any of these holds: it lies outside the 64x64 window whose top-left corner is the latched position (column `pos_x` to `pos_x+63`, row `pos_y` to `pos_y+63`, both ends inclusive), or no valid frame-start pixel has been seen since reset.
- R4: With `cfg_mode` = 0 (tricolour), codes 1, 2 and 3 paint `cfg_color1`, `cfg_color2` and `cfg_color3`. At `cfg_alpha` = 15 the output equals that colour exactly.
- R5: With `cfg_mode` = 1 (two-colour plus invert), codes 1 and 2 paint `cfg_color1` and `cfg_color2`. Code 3 outputs the bitwise complement of every 8-bit component of the background, and `cfg_alpha` has no effect on it.
- R6: Code 0 leaves the background pixel unchanged in both modes.
- R7: A painted colour `c` over background `b` gives, per component, `(c*(a+1) + b*(15-a)) / 16` rounded down, where `a` is `cfg_alpha`. Pixels are packed R in bits 23:16, G in 15:8 and B in 7:0.
- R8: `cfg_pos_x` and `cfg_pos_y` are latched only on a pixel with both `in_valid` and `in_sof` high, and that pixel already uses the new position. A change at any other time has no effect until the next such pixel.
- R9: A write with `bm_we` high stores `bm_code` at image row `bm_row`, column `bm_col`. Pixels presented from the next cycle on use the stored code. The cells at the window's four corners map to rows and columns 0 and 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming pixel is valid |
| in_sof | input | 1 | Incoming pixel is the first of a frame |
| in_x | input | 12 | Column of the incoming pixel |
| in_y | input | 12 | Row of the incoming pixel |
| in_rgb | input | 24 | Background pixel, R/G/B in bits 23:16/15:8/7:0 |
| cfg_pos_x | input | 12 | Cursor left column, latched at frame start |
| cfg_pos_y | input | 12 | Cursor top row, latched at frame start |
| cfg_mode | input | 1 | 0 = three colours, 1 = two colours plus invert |
| cfg_color1 | input | 24 | Colour for code 1 |
| cfg_color2 | input | 24 | Colour for code 2 |
| cfg_color3 | input | 24 | Colour for code 3 in tricolour mode |
| cfg_alpha | input | 4 | Cursor opacity, 15 = fully opaque |
| bm_we | input | 1 | Image write strobe |
| bm_row | input | 6 | Image row to write |
| bm_col | input | 6 | Image column to write |
| bm_code | input | 2 | Code to store |
| out_valid | output | 1 | Outgoing pixel is valid |
| out_sof | output | 1 | Outgoing pixel is the first of a frame |
| out_rgb | output | 24 | Composited pixel |

## Verification
A stale or mis-loaded position register does not corrupt pixels at random. It moves the whole cursor, and the error appears at the first covered pixel after the faulty frame start, two cycles after that pixel enters. A wrong state in the frame-state machine shows as cursor pixels before any frame start, or as missing cursor pixels after one. A stage skew between the flags and the pixel data shows on every pixel as a valid or frame-start mismatch, two cycles after the pixel enters. A corrupted image cell or a wrong code decode appears only when a covered pixel reads that cell. The bench therefore sweeps every code under both modes and all sixteen alpha values, and probes the window edges one pixel inside and outside.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    localparam int CODE_W = 2;

    typedef enum logic {
        MODE_TRICOLOR    = 1'b0,
        MODE_BICOLOR_INV = 1'b1
    } hwc_mode_e;

    typedef enum logic {
        ST_NO_FRAME = 1'b0,
        ST_IN_FRAME = 1'b1
    } hwc_state_e;

    localparam logic [CODE_W-1:0] CODE_CLEAR = 2'd0;
    localparam logic [CODE_W-1:0] CODE_COL1  = 2'd1;
    localparam logic [CODE_W-1:0] CODE_COL2  = 2'd2;
    localparam logic [CODE_W-1:0] CODE_TOP   = 2'd3;

endpackage

// File: rtl/hwc_window.sv
module hwc_window
    import hwc_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int CUR_DIM = 64,
    localparam int IDX_W = $clog2(CUR_DIM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [COORD_W-1:0] cfg_pos_x,
    input  logic [COORD_W-1:0] cfg_pos_y,
    output logic               hit,
    output logic [IDX_W-1:0]   row_idx,
    output logic [IDX_W-1:0]   col_idx
);

    localparam logic [COORD_W-1:0] DIM_C = COORD_W'(CUR_DIM);

    hwc_state_e         state_q, state_d;
    logic [COORD_W-1:0] pos_x_q, pos_y_q;
    logic [COORD_W-1:0] eff_x, eff_y;
    logic [COORD_W:0]   dx, dy;
    logic               frame_start, armed;

    assign frame_start = in_valid && in_sof;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NO_FRAME;
        else        state_q <= state_d;
    end

    // Next state: first frame start arms the cursor for good
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NO_FRAME: if (frame_start) state_d = ST_IN_FRAME;
            ST_IN_FRAME: state_d = ST_IN_FRAME;
            default:     state_d = ST_NO_FRAME;
        endcase
    end

    // Position shadow: loaded only at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_x_q <= '0;
            pos_y_q <= '0;
        end else if (frame_start) begin
            pos_x_q <= cfg_pos_x;
            pos_y_q <= cfg_pos_y;
        end
    end

    // Outputs: window test against the position in force for this pixel
    always_comb begin
        armed   = frame_start || (state_q == ST_IN_FRAME);
        eff_x   = frame_start ? cfg_pos_x : pos_x_q;
        eff_y   = frame_start ? cfg_pos_y : pos_y_q;
        dx      = {1'b0, in_x} - {1'b0, eff_x};
        dy      = {1'b0, in_y} - {1'b0, eff_y};
        hit     = in_valid && armed
                  && !dx[COORD_W] && (dx[COORD_W-1:0] < DIM_C)
                  && !dy[COORD_W] && (dy[COORD_W-1:0] < DIM_C);
        col_idx = dx[IDX_W-1:0];
        row_idx = dy[IDX_W-1:0];
    end

    // R8: latched position only moves on a valid frame-start pixel
    p_pos_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_sof) |=> ($stable(pos_x_q) && $stable(pos_y_q)));

endmodule

// File: rtl/hwc_bitmap.sv
module hwc_bitmap
    import hwc_pkg::*;
#(
    parameter int CUR_DIM = 64,
    localparam int IDX_W = $clog2(CUR_DIM),
    localparam int ROW_W = CODE_W * CUR_DIM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_row,
    input  logic [IDX_W-1:0]  wr_col,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [IDX_W-1:0]  rd_row,
    input  logic [IDX_W-1:0]  rd_col,
    output logic [CODE_W-1:0] rd_code
);

    // One word per cursor row, cells packed CODE_W bits apart
    logic [ROW_W-1:0] rows [CUR_DIM];

    always_ff @(posedge clk) begin
        if (wr_en) rows[wr_row][{wr_col, 1'b0} +: CODE_W] <= wr_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_code <= CODE_CLEAR;
        else        rd_code <= rows[rd_row][{rd_col, 1'b0} +: CODE_W];
    end

endmodule

// File: rtl/hwc_compose.sv
module hwc_compose
    import hwc_pkg::*;
#(
    parameter int COMP_W  = 8,
    parameter int ALPHA_W = 4,
    localparam int PIX_W  = 3 * COMP_W,
    localparam int SUM_W  = COMP_W + ALPHA_W + 1,
    localparam int AMAX   = (1 << ALPHA_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [PIX_W-1:0]   in_rgb,
    input  logic               in_hit,
    input  logic [CODE_W-1:0]  s1_code,
    input  logic               cfg_mode,
    input  logic [PIX_W-1:0]   cfg_color1,
    input  logic [PIX_W-1:0]   cfg_color2,
    input  logic [PIX_W-1:0]   cfg_color3,
    input  logic [ALPHA_W-1:0] cfg_alpha,
    output logic               out_valid,
    output logic               out_sof,
    output logic [PIX_W-1:0]   out_rgb
);

    logic             s1_valid, s1_sof, s1_hit;
    logic [PIX_W-1:0] s1_rgb;
    logic [PIX_W-1:0] paint_rgb, blend_rgb, pix_d;
    logic             do_invert;

    // Stage 1: align the pixel with the code read from the image
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sof   <= 1'b0;
            s1_hit   <= 1'b0;
            s1_rgb   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_sof   <= in_sof;
            s1_hit   <= in_hit;
            s1_rgb   <= in_rgb;
        end
    end

    // Code decode under the selected mode
    always_comb begin
        paint_rgb = cfg_color1;
        do_invert = 1'b0;
        unique case (s1_code)
            CODE_CLEAR: paint_rgb = cfg_color1;
            CODE_COL1:  paint_rgb = cfg_color1;
            CODE_COL2:  paint_rgb = cfg_color2;
            CODE_TOP: begin
                if (hwc_mode_e'(cfg_mode) == MODE_BICOLOR_INV) do_invert = 1'b1;
                else                                           paint_rgb = cfg_color3;
            end
        endcase
    end

    // Per-component alpha mix
    for (genvar g = 0; g < 3; g++) begin : g_comp
        logic [SUM_W-1:0] w_fg, w_bg, w_sum;
        assign w_fg  = SUM_W'(paint_rgb[g*COMP_W +: COMP_W]) * (SUM_W'(cfg_alpha) + SUM_W'(1));
        assign w_bg  = SUM_W'(s1_rgb[g*COMP_W +: COMP_W]) * (SUM_W'(AMAX) - SUM_W'(cfg_alpha));
        assign w_sum = w_fg + w_bg;
        assign blend_rgb[g*COMP_W +: COMP_W] = w_sum[ALPHA_W +: COMP_W];
    end

    always_comb begin
        if (!s1_hit || s1_code == CODE_CLEAR) pix_d = s1_rgb;
        else if (do_invert)                   pix_d = ~s1_rgb;
        else                                  pix_d = blend_rgb;
    end

    // Stage 2: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_sof   <= s1_sof;
            out_rgb   <= pix_d;
        end
    end

    // R3: uncovered pixels leave untouched
    p_pass_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_hit |=> (out_rgb == $past(s1_rgb)));

    // R6: code 0 is see-through in both modes
    p_clear_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_hit && s1_code == CODE_CLEAR) |=> (out_rgb == $past(s1_rgb)));

    // R5: invert code complements the background whatever the alpha
    p_invert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_hit && s1_code == CODE_TOP && cfg_mode == 1'b1)
        |=> (out_rgb == ~$past(s1_rgb)));

    // R4: fully opaque colour 1 is reproduced exactly
    p_solid_color_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_hit && s1_code == CODE_COL1 && cfg_alpha == '1)
        |=> (out_rgb == $past(cfg_color1)));

endmodule

// File: rtl/hwc_overlay.sv
module hwc_overlay
    import hwc_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int CUR_DIM = 64,
    parameter int COMP_W  = 8,
    parameter int ALPHA_W = 4,
    localparam int PIX_W  = 3 * COMP_W,
    localparam int IDX_W  = $clog2(CUR_DIM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [PIX_W-1:0]   in_rgb,
    input  logic [COORD_W-1:0] cfg_pos_x,
    input  logic [COORD_W-1:0] cfg_pos_y,
    input  logic               cfg_mode,
    input  logic [PIX_W-1:0]   cfg_color1,
    input  logic [PIX_W-1:0]   cfg_color2,
    input  logic [PIX_W-1:0]   cfg_color3,
    input  logic [ALPHA_W-1:0] cfg_alpha,
    input  logic               bm_we,
    input  logic [IDX_W-1:0]   bm_row,
    input  logic [IDX_W-1:0]   bm_col,
    input  logic [CODE_W-1:0]  bm_code,
    output logic               out_valid,
    output logic               out_sof,
    output logic [PIX_W-1:0]   out_rgb
);

    logic              win_hit;
    logic [IDX_W-1:0]  win_row, win_col;
    logic [CODE_W-1:0] s1_code;

    hwc_window #(.COORD_W(COORD_W), .CUR_DIM(CUR_DIM)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_x      (in_x),
        .in_y      (in_y),
        .cfg_pos_x (cfg_pos_x),
        .cfg_pos_y (cfg_pos_y),
        .hit       (win_hit),
        .row_idx   (win_row),
        .col_idx   (win_col)
    );

    hwc_bitmap #(.CUR_DIM(CUR_DIM)) u_bitmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bm_we),
        .wr_row  (bm_row),
        .wr_col  (bm_col),
        .wr_code (bm_code),
        .rd_row  (win_row),
        .rd_col  (win_col),
        .rd_code (s1_code)
    );

    hwc_compose #(.COMP_W(COMP_W), .ALPHA_W(ALPHA_W)) u_compose (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_rgb     (in_rgb),
        .in_hit     (win_hit),
        .s1_code    (s1_code),
        .cfg_mode   (cfg_mode),
        .cfg_color1 (cfg_color1),
        .cfg_color2 (cfg_color2),
        .cfg_color3 (cfg_color3),
        .cfg_alpha  (cfg_alpha),
        .out_valid  (out_valid),
        .out_sof    (out_sof),
        .out_rgb    (out_rgb)
    );

    // R2: flags emerge exactly two cycles after entry
    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    p_idle_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);
    p_sof_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_sof |-> ##2 out_sof);

endmodule

// File: tb/hwc_overlay_tb.sv
module hwc_overlay_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_sof;
    logic [11:0] in_x, in_y;
    logic [23:0] in_rgb;
    logic [11:0] cfg_pos_x, cfg_pos_y;
    logic        cfg_mode;
    logic [23:0] cfg_color1, cfg_color2, cfg_color3;
    logic [3:0]  cfg_alpha;
    logic        bm_we;
    logic [5:0]  bm_row, bm_col;
    logic [1:0]  bm_code;
    logic        out_valid, out_sof;
    logic [23:0] out_rgb;

    always #10 clk = ~clk;

    hwc_overlay u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_x(in_x), .in_y(in_y), .in_rgb(in_rgb),
        .cfg_pos_x(cfg_pos_x), .cfg_pos_y(cfg_pos_y), .cfg_mode(cfg_mode),
        .cfg_color1(cfg_color1), .cfg_color2(cfg_color2), .cfg_color3(cfg_color3),
        .cfg_alpha(cfg_alpha), .bm_we(bm_we), .bm_row(bm_row), .bm_col(bm_col),
        .bm_code(bm_code), .out_valid(out_valid), .out_sof(out_sof), .out_rgb(out_rgb)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    bit    mdl_live = 0;
    int    mdl_px = 0, mdl_py = 0, seed = 0;
    bit          p_act [2];
    bit          p_val [2];
    bit          p_sof [2];
    logic [23:0] p_rgb [2];
    string       p_tag [2];

    function automatic int pat(int r, int c, int s);
        return (3 * r + c + s) % 4;
    endfunction

    function automatic logic [23:0] mix(logic [23:0] col, logic [23:0] bg, int a);
        logic [23:0] res;
        for (int k = 0; k < 3; k++) begin
            int cc = int'(col[8*k +: 8]);
            int bb = int'(bg[8*k +: 8]);
            res[8*k +: 8] = 8'((cc * (a + 1) + bb * (15 - a)) / 16);
        end
        return res;
    endfunction

    task automatic check_bit(string req, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %b expected %b", req, got, exp);
        end
    endtask

    // One pixel per call; checks the pixel sent two calls earlier
    task automatic step(bit v, bit s, int x, int y, logic [23:0] rgb, string tag = "");
        logic [23:0] e;
        string       t;
        int          dxm, dym, code;
        @(negedge clk);
        if (p_act[1]) begin
            n_checks++;
            if (out_valid !== p_val[1] || out_sof !== p_sof[1]) begin
                n_fail++;
                $display("FAIL R2 valid/sof got %b/%b expected %b/%b",
                         out_valid, out_sof, p_val[1], p_sof[1]);
            end
            if (p_val[1]) begin
                n_checks++;
                if (out_rgb !== p_rgb[1]) begin
                    n_fail++;
                    $display("FAIL %s pixel got %h expected %h", p_tag[1], out_rgb, p_rgb[1]);
                end
            end
        end
        if (v && s) begin
            mdl_live = 1;
            mdl_px   = int'(cfg_pos_x);
            mdl_py   = int'(cfg_pos_y);
        end
        dxm = x - mdl_px;
        dym = y - mdl_py;
        if (!mdl_live || dxm < 0 || dxm > 63 || dym < 0 || dym > 63) begin
            e = rgb; t = "R3";
        end else begin
            code = pat(dym, dxm, seed);
            if (code == 0) begin
                e = rgb; t = "R6";
            end else if (code == 3 && cfg_mode) begin
                e = ~rgb; t = "R5";
            end else begin
                e = mix(code == 1 ? cfg_color1 : code == 2 ? cfg_color2 : cfg_color3,
                        rgb, int'(cfg_alpha));
                t = (cfg_alpha != 4'd15) ? "R7" : (cfg_mode ? "R5" : "R4");
            end
        end
        if (tag != "") t = tag;
        p_act[1] = p_act[0]; p_val[1] = p_val[0]; p_sof[1] = p_sof[0];
        p_rgb[1] = p_rgb[0]; p_tag[1] = p_tag[0];
        p_act[0] = 1'b1; p_val[0] = v; p_sof[0] = s; p_rgb[0] = e; p_tag[0] = t;
        in_valid = v; in_sof = s; in_x = 12'(x); in_y = 12'(y); in_rgb = rgb;
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, 0, 24'h0);
    endtask

    task automatic load_bitmap(int s);
        for (int r = 0; r < 64; r++) begin
            for (int c = 0; c < 64; c++) begin
                @(negedge clk);
                bm_we = 1'b1; bm_row = 6'(r); bm_col = 6'(c); bm_code = 2'(pat(r, c, s));
            end
        end
        @(negedge clk);
        bm_we = 1'b0;
        seed = s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog got 200000 cycles expected fewer");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        p_act = '{0, 0}; p_val = '{0, 0}; p_sof = '{0, 0};
        rst_n = 1'b0; in_valid = 0; in_sof = 0; in_x = 0; in_y = 0; in_rgb = 0;
        cfg_pos_x = 12'd100; cfg_pos_y = 12'd50; cfg_mode = 1'b0;
        cfg_color1 = 24'hF01020; cfg_color2 = 24'h30E040; cfg_color3 = 24'h5060D0;
        cfg_alpha = 4'd15; bm_we = 0; bm_row = 0; bm_col = 0; bm_code = 0;

        // R1: reset state
        repeat (4) @(negedge clk);
        check_bit("R1 out_valid", out_valid, 1'b0);
        check_bit("R1 out_sof", out_sof, 1'b0);
        n_checks++;
        if (out_rgb !== 24'h0) begin
            n_fail++;
            $display("FAIL R1 out_rgb got %h expected %h", out_rgb, 24'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 idle after release", out_valid, 1'b0);

        // R9: image load through the write port
        load_bitmap(0);

        // R3: no frame start yet, covered pixels pass through
        step(1, 0, 101, 50, 24'h123456);
        step(1, 0, 103, 51, 24'h654321);
        step(1, 0, 110, 60, 24'hABCDEF);
        flush();

        // first frame start pixel, outside the window
        step(1, 1, 0, 0, 24'h0F0F0F);

        // Sweep: both modes, all alphas, every code (R4 R5 R6 R7)
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                flush();
                cfg_mode  = m[0];
                cfg_alpha = 4'(a);
                for (int code = 0; code < 4; code++) begin
                    int r = (a * 3 + m * 29 + code * 5) % 64;
                    int c = (((code - 3 * r - seed) % 4) + 4) % 4 + 4 * a;
                    logic [23:0] bg = {8'(a * 16 + code), 8'(m * 100 + a * 7), 8'(255 - a * 13)};
                    step(1, 0, 100 + c, 50 + r, bg);
                    if (code == 1) step(0, 0, 100 + c, 50 + r, bg);
                end
            end
        end

        // Window edges: just outside (R3) and the four corners (R9)
        flush();
        cfg_mode = 1'b0; cfg_alpha = 4'd15;
        step(1, 0, 99, 60, 24'h111111);
        step(1, 0, 164, 60, 24'h222222);
        step(1, 0, 120, 49, 24'h333333);
        step(1, 0, 120, 114, 24'h444444);
        step(1, 0, 100, 50, 24'h556677, "R9");
        step(1, 0, 163, 50, 24'h8899AA, "R9");
        step(1, 0, 100, 113, 24'hBBCCDD, "R9");
        step(1, 0, 163, 113, 24'hEEFF00, "R9");
        step(1, 0, 101, 50, 24'h010203, "R9");

        // R8: position change mid-frame is held until the next frame start
        flush();
        cfg_pos_x = 12'd300; cfg_pos_y = 12'd200;
        step(1, 0, 101, 50, 24'h1A2B3C, "R8");
        step(1, 0, 301, 200, 24'h4D5E6F, "R8");
        step(1, 1, 301, 200, 24'h778899, "R8");
        step(1, 0, 101, 50, 24'h1A2B3C, "R8");
        step(1, 0, 302, 201, 24'hC0FFEE, "R8");

        // R9: rewritten image takes effect
        flush();
        load_bitmap(1);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++)
                step(1, 0, 300 + c, 200 + r, 24'(32'h00102030 + r * 32'h0A0B0C + c), "R9");
        flush();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule